// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block turns an internal memory request of a small 8-bit core into one bus cycle on an external multiplexed address/data port. Each cycle has an address phase (T1) and a data phase (T2). The block runs on a clock `clk` at twice the system rate. Every system clock period is two `clk` cycles: the first cycle is the clock-high half and the second is the clock-low half. The address strobe is low only in the high half of T1. The selected data strobe is low only in the high half of T2. Because of this, every strobe edge falls on a half-phase boundary, and all outputs still come straight from flip-flops.

Two data strobes share the external space. When the second strobe is enabled, the address bit at `SEL_BIT` picks between an upper memory and a lower memory, so two devices can sit on the bus with no decoder between them. If the request is flagged internal, the block still runs the address phase, but both data strobes stay high. An external device can stretch T2 with `wait_i`. An external master can take the bus with `breq_i`. When the bus is handed over, or when the software float control is set, the strobes and the port are released: their output enables go low.

The requester raises `req_i` for one `clk` cycle while the block is idle. It then waits for `done_o`.

Top module: `ebc_strobe_ctrl`

## Requirements
- R1: After a request is accepted, `as_n_o` is low for exactly the next one `clk` cycle (T1 high half). It is high for the `clk` cycle after that (T1 low half). During both T1 cycles, `ad_o` carries address bits [DATA_W-1:0] with `ad_oe_o`=1, and `addr_hi_o` carries the remaining upper address bits.
- R2: In the T2 high half (the third `clk` cycle after acceptance) exactly one data strobe is low on an external access. `ds2_n_o` is used when `ds2_en_i`=1 and address bit 21 is 0. `ds_n_o` is used in every other case, including any access made with `ds2_en_i`=0.
- R3: On an external read, `rdata_o` takes the value of `ad_i` sampled in the last `clk` cycle in which the data strobe is low. `ad_oe_o` is 0 throughout T2. `done_o` is high for exactly one `clk` cycle, the T2 low half.
- R4: On an external write, `ad_o` carries the write data with `ad_oe_o`=1 from the cycle in which the data strobe falls through the cycle in which it rises.
- R5: On an internal access, `ds_n_o` and `ds2_n_o` stay high for the whole cycle, `ad_oe_o` is 0 in T2, `wait_i` is ignored, and `rdata_o` keeps its previous value.
- R6: On an external access, each `clk` edge in the T2 high half at which `wait_i`=1 extends T2 by one whole system period (two `clk` cycles). The data strobe stays low until a high-half edge sees `wait_i`=0.
- R7: `breq_i` is acted on only between cycles. `back_o` rises one `clk` cycle after `breq_i` is seen high in idle, and falls one `clk` cycle after `breq_i` is seen low. A `req_i` pulse while `breq_i` or `back_o` is high starts no cycle.
- R8: While `back_o`=1, and one `clk` cycle after `hiz_i` is seen high, `strb_oe_o`=0 and `ad_oe_o`=0.
- R9: While `rst`=1, the strobes are driven high (`strb_oe_o`=1), `ad_oe_o`=0, and `done_o`=0 and `back_o`=0 on the following edge, even in the middle of a cycle.
- R10: At most one of `as_n_o`, `ds_n_o`, `ds2_n_o` is low in any `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock, twice the system rate |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle access request, sampled in idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_int_i | input | 1 | 1 = internal memory target |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| ds2_en_i | input | 1 | Enables steering by the select bit |
| hiz_i | input | 1 | Software float control |
| wait_i | input | 1 | External wait request |
| breq_i | input | 1 | External bus request |
| ad_i | input | DATA_W | Port input (read data) |
| ad_o | output | DATA_W | Port output (address low / write data) |
| ad_oe_o | output | 1 | Port output enable |
| addr_hi_o | output | ADDR_W-DATA_W | Upper address bits |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Upper-block data strobe, active low |
| ds2_n_o | output | 1 | Lower-block data strobe, active low |
| strb_oe_o | output | 1 | Output enable of strobes and upper address |
| back_o | output | 1 | Bus acknowledge |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | DATA_W | Captured read data |

## Verification
The hardest states to reach from the ports are the stretched data phase and the rule that `wait_i` is ignored on internal accesses. Both depend on `wait_i` being high at one particular edge. The stimulus therefore walks the cycle one half-phase at a time. At each high-half sample it sets `wait_i` from a per-vector count of wait states, so the strobe level can be checked in every stretched cycle. The bus handoff is reached by raising `breq_i` while idle and then sending a request pulse during the grant. Quiet outputs before and after the release show that no cycle was started or left pending.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_T1A   = 3'd1,
    ST_T1B   = 3'd2,
    ST_T2A   = 3'd3,
    ST_T2W   = 3'd4,
    ST_T2B   = 3'd5,
    ST_GRANT = 3'd6
  } ebc_state_e;
endpackage

// File: rtl/ebc_fsm.sv
module ebc_fsm
  import ebc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       breq_i,
  input  logic       wait_i,
  input  logic       int_q,
  output logic       accept_o,
  output ebc_state_e st_q,
  output ebc_state_e st_d
);
  assign accept_o = (st_q == ST_IDLE) && req_i && !breq_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (breq_i) st_d = ST_GRANT;
                else if (req_i) st_d = ST_T1A;
      ST_T1A:   st_d = ST_T1B;
      ST_T1B:   st_d = ST_T2A;
      ST_T2A:   st_d = (wait_i && !int_q) ? ST_T2W : ST_T2B;
      ST_T2W:   st_d = ST_T2A;
      ST_T2B:   st_d = ST_IDLE;
      ST_GRANT: if (!breq_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/ebc_req_latch.sv
module ebc_req_latch #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              we_i,
  input  logic              int_i,
  input  logic              ds2en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              int_q,
  output logic              we_d,
  output logic              int_d,
  output logic              ds2en_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] wdata_d
);
  logic              we_q, ds2en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b0; int_q <= 1'b0; ds2en_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
    end else if (accept_i) begin
      we_q <= we_i; int_q <= int_i; ds2en_q <= ds2en_i;
      addr_q <= addr_i; wdata_q <= wdata_i;
    end
  end

  // Values that will be held after this edge, so output registers line up.
  assign we_d    = accept_i ? we_i    : we_q;
  assign int_d   = accept_i ? int_i   : int_q;
  assign ds2en_d = accept_i ? ds2en_i : ds2en_q;
  assign addr_d  = accept_i ? addr_i  : addr_q;
  assign wdata_d = accept_i ? wdata_i : wdata_q;
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 21
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ebc_state_e               st_q,
  input  ebc_state_e               st_d,
  input  logic                     we_d,
  input  logic                     int_d,
  input  logic                     ds2en_d,
  input  logic [ADDR_W-1:0]        addr_d,
  input  logic [DATA_W-1:0]        wdata_d,
  input  logic                     hiz_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     as_n_o,
  output logic                     ds_n_o,
  output logic                     ds2_n_o,
  output logic                     strb_oe_o,
  output logic                     back_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic in_t1, in_dsl, in_t2, ext, upper, drive_en;

  assign in_t1    = (st_d == ST_T1A) || (st_d == ST_T1B);
  assign in_dsl   = (st_d == ST_T2A) || (st_d == ST_T2W);
  assign in_t2    = in_dsl || (st_d == ST_T2B);
  assign ext      = !int_d;
  assign upper    = !ds2en_d || addr_d[SEL_BIT];
  assign drive_en = !hiz_i && (st_d != ST_GRANT);

  always_ff @(posedge clk) begin
    if (rst) begin
      as_n_o    <= 1'b1;
      ds_n_o    <= 1'b1;
      ds2_n_o   <= 1'b1;
      strb_oe_o <= 1'b1;
      ad_oe_o   <= 1'b0;
      ad_o      <= '0;
      addr_hi_o <= '0;
      back_o    <= 1'b0;
      done_o    <= 1'b0;
      rdata_o   <= '0;
    end else begin
      as_n_o    <= !(st_d == ST_T1A);
      ds_n_o    <= !(in_dsl && ext && upper);
      ds2_n_o   <= !(in_dsl && ext && !upper);
      strb_oe_o <= drive_en;
      ad_oe_o   <= drive_en && (in_t1 || (in_t2 && ext && we_d));
      ad_o      <= in_t1 ? addr_d[DATA_W-1:0] : wdata_d;
      addr_hi_o <= addr_d[ADDR_W-1:DATA_W];
      back_o    <= (st_d == ST_GRANT);
      done_o    <= (st_d == ST_T2B);
      if (st_q == ST_T2A && st_d == ST_T2B && ext && !we_d)
        rdata_o <= ad_i;
    end
  end
endmodule

// File: rtl/ebc_strobe_ctrl.sv
module ebc_strobe_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 21
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic                     req_we_i,
  input  logic                     req_int_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic                     ds2_en_i,
  input  logic                     hiz_i,
  input  logic                     wait_i,
  input  logic                     breq_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     as_n_o,
  output logic                     ds_n_o,
  output logic                     ds2_n_o,
  output logic                     strb_oe_o,
  output logic                     back_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o
);
  ebc_state_e        st_q, st_d;
  logic              accept, int_q, we_d, int_d, ds2en_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;

  ebc_fsm u_fsm (
    .clk(clk), .rst(rst), .req_i(req_i), .breq_i(breq_i), .wait_i(wait_i),
    .int_q(int_q), .accept_o(accept), .st_q(st_q), .st_d(st_d)
  );

  ebc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .accept_i(accept), .we_i(req_we_i),
    .int_i(req_int_i), .ds2en_i(ds2_en_i), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i), .int_q(int_q), .we_d(we_d), .int_d(int_d),
    .ds2en_d(ds2en_d), .addr_d(addr_d), .wdata_d(wdata_d)
  );

  ebc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)) u_pins (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d), .we_d(we_d),
    .int_d(int_d), .ds2en_d(ds2en_d), .addr_d(addr_d), .wdata_d(wdata_d),
    .hiz_i(hiz_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .addr_hi_o(addr_hi_o), .as_n_o(as_n_o), .ds_n_o(ds_n_o),
    .ds2_n_o(ds2_n_o), .strb_oe_o(strb_oe_o), .back_o(back_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/ebc_strobe_chk.sv
module ebc_strobe_chk (
  input logic clk,
  input logic rst,
  input logic breq_i,
  input logic as_n_o,
  input logic ds_n_o,
  input logic ds2_n_o,
  input logic strb_oe_o,
  input logic ad_oe_o,
  input logic back_o,
  input logic done_o
);
  a_r1_as_single: assert property (@(posedge clk) disable iff (rst)
    !as_n_o |=> as_n_o);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({~as_n_o, ~ds_n_o, ~ds2_n_o}) <= 1);
  a_r8_float_on_grant: assert property (@(posedge clk) disable iff (rst)
    back_o |-> (!strb_oe_o && !ad_oe_o));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(back_o) |-> $past(breq_i));
  a_r2_ds_after_t1: assert property (@(posedge clk) disable iff (rst)
    ($fell(ds_n_o) || $fell(ds2_n_o)) |-> $past(as_n_o));
endmodule

bind ebc_strobe_ctrl ebc_strobe_chk u_chk (
  .clk(clk), .rst(rst), .breq_i(breq_i), .as_n_o(as_n_o), .ds_n_o(ds_n_o),
  .ds2_n_o(ds2_n_o), .strb_oe_o(strb_oe_o), .ad_oe_o(ad_oe_o),
  .back_o(back_o), .done_o(done_o)
);

// File: tb/tb_ebc_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_ebc_strobe_ctrl;
  localparam int AW = 22;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 0, req_we_i = 0, req_int_i = 0, ds2_en_i = 0;
  logic hiz_i = 0, wait_i = 0, breq_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0, ad_i = '0;
  logic [DW-1:0] ad_o, rdata_o;
  logic [AW-DW-1:0] addr_hi_o;
  logic ad_oe_o, as_n_o, ds_n_o, ds2_n_o, strb_oe_o, back_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ebc_strobe_ctrl dut (
    .clk(clk), .rst(rst), .req_i(req_i), .req_we_i(req_we_i),
    .req_int_i(req_int_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .ds2_en_i(ds2_en_i), .hiz_i(hiz_i), .wait_i(wait_i), .breq_i(breq_i),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .addr_hi_o(addr_hi_o),
    .as_n_o(as_n_o), .ds_n_o(ds_n_o), .ds2_n_o(ds2_n_o),
    .strb_oe_o(strb_oe_o), .back_o(back_o), .done_o(done_o),
    .rdata_o(rdata_o)
  );

  typedef struct packed {
    logic          we;
    logic          intl;
    logic          ds2en;
    logic [1:0]    nwait;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdin;
    logic          exp_ds;
    logic          exp_ds2;
    logic [DW-1:0] exp_rd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 2'd0, 22'h200012, 8'h00, 8'hA5, 1'b0, 1'b1, 8'hA5},
    '{1'b0, 1'b0, 1'b1, 2'd2, 22'h000034, 8'h00, 8'h3C, 1'b1, 1'b0, 8'h3C},
    '{1'b1, 1'b0, 1'b1, 2'd0, 22'h1FFF56, 8'h9E, 8'h00, 1'b1, 1'b0, 8'h3C},
    '{1'b1, 1'b0, 1'b0, 2'd1, 22'h000078, 8'h61, 8'h00, 1'b0, 1'b1, 8'h3C},
    '{1'b0, 1'b1, 1'b1, 2'd1, 22'h200011, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h3C},
    '{1'b0, 1'b0, 1'b0, 2'd0, 22'h0000C0, 8'h00, 8'h5A, 1'b0, 1'b1, 8'h5A}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int eff;
    bit drv;
    eff = v.intl ? 0 : int'(v.nwait);
    drv = v.we && !v.intl;
    @(negedge clk);
    req_i = 1; req_we_i = v.we; req_int_i = v.intl; ds2_en_i = v.ds2en;
    req_addr_i = v.addr; req_wdata_i = v.wdata; ad_i = v.rdin;
    @(negedge clk);                       // T1 high half
    req_i = 0;
    chk(as_n_o == 1'b0, $sformatf("R1 v%0d as low", idx), 32'(as_n_o), 0);
    chk(ad_oe_o && ad_o == v.addr[DW-1:0], $sformatf("R1 v%0d addr lo", idx),
        32'(ad_o), 32'(v.addr[DW-1:0]));
    chk(addr_hi_o == v.addr[AW-1:DW], $sformatf("R1 v%0d addr hi", idx),
        32'(addr_hi_o), 32'(v.addr[AW-1:DW]));
    @(negedge clk);                       // T1 low half
    chk(as_n_o == 1'b1 && ad_o == v.addr[DW-1:0],
        $sformatf("R1 v%0d as high, addr held", idx), 32'(as_n_o), 1);
    @(negedge clk);                       // T2 high half
    chk({ds_n_o, ds2_n_o} == {v.exp_ds, v.exp_ds2},
        $sformatf("R2 R5 v%0d strobe select", idx),
        32'({ds_n_o, ds2_n_o}), 32'({v.exp_ds, v.exp_ds2}));
    chk(ad_oe_o == drv && (!drv || ad_o == v.wdata),
        $sformatf("R4 R3 v%0d T2 bus", idx), 32'({ad_oe_o, ad_o}),
        32'({drv, drv ? v.wdata : ad_o}));
    wait_i = (v.nwait != 0);
    for (int j = 0; j < eff; j++) begin
      @(negedge clk);                     // stretched low half
      chk({ds_n_o, ds2_n_o} == {v.exp_ds, v.exp_ds2} && !done_o,
          $sformatf("R6 v%0d wait low half %0d", idx, j),
          32'({done_o, ds_n_o, ds2_n_o}), 32'({1'b0, v.exp_ds, v.exp_ds2}));
      @(negedge clk);                     // repeated high half
      chk({ds_n_o, ds2_n_o} == {v.exp_ds, v.exp_ds2},
          $sformatf("R6 v%0d wait high half %0d", idx, j),
          32'({ds_n_o, ds2_n_o}), 32'({v.exp_ds, v.exp_ds2}));
      wait_i = (j + 1 < eff);
    end
    @(negedge clk);                       // T2 low half
    wait_i = 0;
    chk(done_o == 1'b1, $sformatf("R3 R5 R6 v%0d done", idx), 32'(done_o), 1);
    chk(ds_n_o && ds2_n_o, $sformatf("R2 v%0d strobes released", idx),
        32'({ds_n_o, ds2_n_o}), 3);
    chk(rdata_o == v.exp_rd, $sformatf("R3 R5 v%0d rdata", idx),
        32'(rdata_o), 32'(v.exp_rd));
    if (drv)
      chk(ad_oe_o && ad_o == v.wdata, $sformatf("R4 v%0d data held", idx),
          32'(ad_o), 32'(v.wdata));
    @(negedge clk);                       // idle
    chk(!done_o && !ad_oe_o, $sformatf("R3 v%0d idle", idx),
        32'({done_o, ad_oe_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(as_n_o && ds_n_o && ds2_n_o && strb_oe_o,
        "R9 reset strobes high", 32'({as_n_o, ds_n_o, ds2_n_o, strb_oe_o}), 15);
    chk(!ad_oe_o && !done_o && !back_o, "R9 reset quiet",
        32'({ad_oe_o, done_o, back_o}), 0);
    rst = 0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R8 software float
    @(negedge clk); hiz_i = 1;
    @(negedge clk);
    chk(!strb_oe_o && !ad_oe_o, "R8 float on hiz", 32'({strb_oe_o, ad_oe_o}), 0);
    hiz_i = 0;
    @(negedge clk);
    chk(strb_oe_o, "R8 drive after hiz", 32'(strb_oe_o), 1);

    // R7 bus handoff
    breq_i = 1;
    @(negedge clk);
    chk(back_o && !strb_oe_o && !ad_oe_o, "R7 R8 grant",
        32'({back_o, strb_oe_o, ad_oe_o}), 4);
    req_i = 1; req_int_i = 0; req_we_i = 0;
    @(negedge clk); req_i = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!done_o && back_o, "R7 request ignored while granted",
          32'({done_o, back_o}), 1);
    end
    breq_i = 0;
    @(negedge clk);
    chk(!back_o && strb_oe_o, "R7 release", 32'({back_o, strb_oe_o}), 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(as_n_o && !done_o, "R7 no pending cycle", 32'({as_n_o, done_o}), 2);
    end

    // R9 reset mid-cycle
    req_i = 1; req_addr_i = 22'h200000; ds2_en_i = 1;
    @(negedge clk); req_i = 0;
    chk(!as_n_o, "R1 as low before reset", 32'(as_n_o), 0);
    rst = 1;
    @(negedge clk);
    chk(as_n_o && ds_n_o && ds2_n_o && !done_o, "R9 reset mid cycle",
        32'({as_n_o, ds_n_o, ds2_n_o, done_o}), 14);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(ds_n_o && ds2_n_o && !done_o, "R9 cycle abandoned",
        32'({ds_n_o, ds2_n_o, done_o}), 6);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule